// File: doc/BRIEF.md
# Converter Output Test Pattern Selector

This block sits between a converter's sample path and its output serializer. A receiver needs known words to prove that it captures the data correctly, so the block can replace live samples with a chosen pattern. A 4-bit mode code picks the source. The sources are live data, three fixed levels, a checkerboard, a one/zero word toggle, two pseudorandom streams taken from an external PRBS generator, and an alternation of two programmable user words. Each pattern has a fixed rule on whether the offset-binary to two's-complement conversion applies to it. An invert control then flips every bit of the result.

The two-word patterns are driven by a small phase state machine with two states, PH_FIRST and PH_SECOND. On every sample the machine takes one of two transitions. ADVANCE moves to the other state. RESTART applies when the mode code differs from the previous sample's code: that sample uses PH_FIRST, and the machine then goes on to PH_SECOND. The chosen word goes through format conversion and inversion and is registered, so the output always appears one clock after the inputs that produced it.

Top module: `tpat_select`

## Requirements
- R1: While reset is high, the output is all zeros. After reset the phase machine is in PH_FIRST and the previous-mode record holds code 0000.
- R2: Mode 0000 and the unassigned codes 1001 to 1111 pass the data input to the output unchanged, apart from inversion. Format select has no effect on them.
- R3: Modes 0001, 0010 and 0011 output 0x800, 0xFFF and 0x000 on every sample.
- R4: Mode 0100 outputs 0xAAA and 0x555 on alternate samples, starting with 0xAAA.
- R5: Mode 0111 outputs 0xFFF and 0x000 on alternate samples, starting with 0xFFF.
- R6: Mode 1000 outputs user word A and user word B on alternate samples, starting with A.
- R7: Modes 0101 (long sequence) and 0110 (short sequence) output the PN word input.
- R8: When format select is 1, the MSB of the word is inverted in modes 0001, 0010, 0011, 0101 and 0110 only. Modes 0100, 0111 and 1000 ignore format select.
- R9: When the invert control is 1, every output bit is flipped. The flip is applied after format conversion.
- R10: A sample whose mode code differs from the previous sample's code outputs the first word of its pattern.
- R11: Every input sample reaches the output exactly one clock later, in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample-rate clock |
| rst_i | input | 1 | Synchronous reset, active high |
| din_i | input | W | Live converter sample |
| mode_i | input | 4 | Pattern selection code |
| fmt_twos_i | input | 1 | 1 selects two's-complement output for patterns that follow format |
| inv_i | input | 1 | 1 flips every output bit |
| user_a_i | input | W | First user-defined word |
| user_b_i | input | W | Second user-defined word |
| pn_word_i | input | W | Word from the PRBS generator |
| dout_o | output | W | Registered output word |

## Verification
The bench builds the block with the default word width of 12. At that width the fixed levels, the checkerboard phases and the PN sample values are the familiar 12-bit words, so every expected value can be written as a literal. The vector table changes modes on purpose partway through an alternation. This checks that RESTART wins over ADVANCE, and that format select and inversion combine in the correct order for every pattern class.

// File: rtl/tpat_pkg.sv
package tpat_pkg;

    typedef enum logic [3:0] {
        MODE_DATA     = 4'd0,
        MODE_MID      = 4'd1,
        MODE_POS      = 4'd2,
        MODE_NEG      = 4'd3,
        MODE_CHECK    = 4'd4,
        MODE_PN_LONG  = 4'd5,
        MODE_PN_SHORT = 4'd6,
        MODE_TOGGLE   = 4'd7,
        MODE_USER     = 4'd8
    } tpat_mode_e;

    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } tpat_phase_e;

endpackage

// File: rtl/tpat_phase_fsm.sv
module tpat_phase_fsm
    import tpat_pkg::*;
#(
    parameter int MODE_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [MODE_W-1:0] mode_i,
    output tpat_phase_e       phase_o
);

    tpat_phase_e       state_q;
    tpat_phase_e       state_d;
    tpat_phase_e       eff;
    logic [MODE_W-1:0] mode_q;
    logic              restart;

    // RESTART when the code moved, otherwise ADVANCE from the held state
    always_comb begin
        restart = (mode_i != mode_q);
        eff     = restart ? PH_FIRST : state_q;
        unique case (eff)
            PH_FIRST:  state_d = PH_SECOND;
            PH_SECOND: state_d = PH_FIRST;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= PH_FIRST;
            mode_q  <= '0;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_i;
        end
    end

    assign phase_o = eff;

    // R10: a changed code always selects the first word for this sample
    assert_restart_first_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_i != mode_q) |-> (phase_o == PH_FIRST));

endmodule

// File: rtl/tpat_word_gen.sv
module tpat_word_gen
    import tpat_pkg::*;
#(
    parameter int W = 12
) (
    input  tpat_mode_e  mode_i,
    input  tpat_phase_e phase_i,
    input  logic [W-1:0] din_i,
    input  logic [W-1:0] pn_i,
    input  logic [W-1:0] user_a_i,
    input  logic [W-1:0] user_b_i,
    output logic [W-1:0] word_o,
    output logic         fmt_ok_o
);

    localparam logic [W-1:0] ALL_ONES  = '1;
    localparam logic [W-1:0] ALL_ZEROS = '0;
    localparam logic [W-1:0] MID_WORD  = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] chk_first;
    logic         first;

    for (genvar i = 0; i < W; i++) begin : g_chk
        assign chk_first[i] = (((W - 1 - i) % 2) == 0);
    end

    assign first = (phase_i == PH_FIRST);

    always_comb begin
        word_o   = din_i;
        fmt_ok_o = 1'b0;
        unique case (mode_i)
            MODE_DATA: begin
                word_o   = din_i;
                fmt_ok_o = 1'b0;
            end
            MODE_MID: begin
                word_o   = MID_WORD;
                fmt_ok_o = 1'b1;
            end
            MODE_POS: begin
                word_o   = ALL_ONES;
                fmt_ok_o = 1'b1;
            end
            MODE_NEG: begin
                word_o   = ALL_ZEROS;
                fmt_ok_o = 1'b1;
            end
            MODE_CHECK: begin
                word_o   = first ? chk_first : ~chk_first;
                fmt_ok_o = 1'b0;
            end
            MODE_PN_LONG, MODE_PN_SHORT: begin
                word_o   = pn_i;
                fmt_ok_o = 1'b1;
            end
            MODE_TOGGLE: begin
                word_o   = first ? ALL_ONES : ALL_ZEROS;
                fmt_ok_o = 1'b0;
            end
            MODE_USER: begin
                word_o   = first ? user_a_i : user_b_i;
                fmt_ok_o = 1'b0;
            end
            default: begin
                word_o   = din_i;
                fmt_ok_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/tpat_out_stage.sv
module tpat_out_stage #(
    parameter int W = 12
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] word_i,
    input  logic         fmt_ok_i,
    input  logic         fmt_twos_i,
    input  logic         inv_i,
    output logic [W-1:0] dout_o
);

    logic         msb_flip;
    logic [W-1:0] fmt_word;
    logic [W-1:0] final_word;

    always_comb begin
        msb_flip   = fmt_ok_i & fmt_twos_i;
        fmt_word   = word_i ^ {msb_flip, {(W-1){1'b0}}};
        final_word = fmt_word ^ {W{inv_i}};
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) dout_o <= '0;
        else       dout_o <= final_word;
    end

    // R1: output cleared one clock after reset is seen
    assert_reset_clear_R1: assert property (@(posedge clk_i)
        rst_i |=> (dout_o == '0));

endmodule

// File: rtl/tpat_select.sv
module tpat_select
    import tpat_pkg::*;
#(
    parameter int W = 12
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] din_i,
    input  logic [3:0]   mode_i,
    input  logic         fmt_twos_i,
    input  logic         inv_i,
    input  logic [W-1:0] user_a_i,
    input  logic [W-1:0] user_b_i,
    input  logic [W-1:0] pn_word_i,
    output logic [W-1:0] dout_o
);

    localparam logic [W-1:0] MID_WORD = {1'b1, {(W-1){1'b0}}};

    tpat_phase_e  phase;
    logic [W-1:0] word;
    logic         fmt_ok;

    tpat_phase_fsm #(.MODE_W(4)) u_phase (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .mode_i  (mode_i),
        .phase_o (phase)
    );

    tpat_word_gen #(.W(W)) u_gen (
        .mode_i   (tpat_mode_e'(mode_i)),
        .phase_i  (phase),
        .din_i    (din_i),
        .pn_i     (pn_word_i),
        .user_a_i (user_a_i),
        .user_b_i (user_b_i),
        .word_o   (word),
        .fmt_ok_o (fmt_ok)
    );

    tpat_out_stage #(.W(W)) u_out (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .word_i     (word),
        .fmt_ok_i   (fmt_ok),
        .fmt_twos_i (fmt_twos_i),
        .inv_i      (inv_i),
        .dout_o     (dout_o)
    );

    // R2 and R11: live data appears one clock later
    assert_data_latency_R11: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_i == 4'd0 && !inv_i) |=> (dout_o == $past(din_i)));

    // R3: midscale level in offset binary
    assert_mid_level_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_i == 4'd1 && !fmt_twos_i && !inv_i) |=> (dout_o == MID_WORD));

    // R7: PN word passes through in offset binary
    assert_pn_pass_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_i == 4'd5 && !fmt_twos_i && !inv_i) |=> (dout_o == $past(pn_word_i)));

    // R4: consecutive checkerboard samples are bitwise complements
    assert_check_toggle_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_i == 4'd4 && $past(mode_i) == 4'd4 && !$past(rst_i) && !inv_i && !$past(inv_i))
        |=> (dout_o == ~$past(dout_o)));

    // R6 and R10: entering user mode starts with word A
    assert_user_first_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_i == 4'd8 && $past(mode_i) != 4'd8 && !$past(rst_i) && !inv_i)
        |=> (dout_o == $past(user_a_i)));

endmodule

// File: tb/tpat_select_test.sv
module tpat_select_test;

    localparam int W  = 12;
    localparam int NV = 24;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] din = '0;
    logic [3:0]   mode = '0;
    logic         fmt = 1'b0;
    logic         inv = 1'b0;
    logic [W-1:0] ua = 12'h3C5;
    logic [W-1:0] ub = 12'h0F0;
    logic [W-1:0] pn = '0;
    logic [W-1:0] dout;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    tpat_select #(.W(W)) uut (
        .clk_i      (clk),
        .rst_i      (rst),
        .din_i      (din),
        .mode_i     (mode),
        .fmt_twos_i (fmt),
        .inv_i      (inv),
        .user_a_i   (ua),
        .user_b_i   (ub),
        .pn_word_i  (pn),
        .dout_o     (dout)
    );

    // {req, mode, fmt, inv, din, pn, expected}
    localparam logic [45:0] VEC [NV] = '{
        {4'd2,  4'd0,  1'b0, 1'b0, 12'h123, 12'h000, 12'h123}, // R2 data
        {4'd9,  4'd0,  1'b0, 1'b1, 12'h123, 12'h000, 12'hEDC}, // R9 invert data
        {4'd3,  4'd1,  1'b0, 1'b0, 12'h000, 12'h000, 12'h800}, // R3 mid
        {4'd8,  4'd1,  1'b1, 1'b0, 12'h000, 12'h000, 12'h000}, // R8 mid twos
        {4'd3,  4'd2,  1'b0, 1'b0, 12'h000, 12'h000, 12'hFFF}, // R3 pos
        {4'd8,  4'd2,  1'b1, 1'b0, 12'h000, 12'h000, 12'h7FF}, // R8 pos twos
        {4'd8,  4'd3,  1'b1, 1'b0, 12'h000, 12'h000, 12'h800}, // R8 neg twos
        {4'd8,  4'd4,  1'b1, 1'b0, 12'h000, 12'h000, 12'hAAA}, // R8 check ignores fmt
        {4'd4,  4'd4,  1'b0, 1'b0, 12'h000, 12'h000, 12'h555}, // R4 second
        {4'd4,  4'd4,  1'b0, 1'b0, 12'h000, 12'h000, 12'hAAA}, // R4 wraps
        {4'd10, 4'd7,  1'b1, 1'b0, 12'h000, 12'h000, 12'hFFF}, // R10 toggle restart
        {4'd5,  4'd7,  1'b0, 1'b0, 12'h000, 12'h000, 12'h000}, // R5 second
        {4'd9,  4'd7,  1'b0, 1'b1, 12'h000, 12'h000, 12'h000}, // R9 toggle first inverted
        {4'd10, 4'd8,  1'b1, 1'b0, 12'h000, 12'h000, 12'h3C5}, // R10 user restart
        {4'd6,  4'd8,  1'b1, 1'b0, 12'h000, 12'h000, 12'h0F0}, // R6 word B
        {4'd6,  4'd8,  1'b0, 1'b0, 12'h000, 12'h000, 12'h3C5}, // R6 word A again
        {4'd7,  4'd5,  1'b0, 1'b0, 12'h000, 12'hDF9, 12'hDF9}, // R7 long
        {4'd7,  4'd6,  1'b1, 1'b0, 12'h000, 12'h353, 12'hB53}, // R7 short twos
        {4'd9,  4'd6,  1'b1, 1'b1, 12'h000, 12'h301, 12'h4FE}, // R9 fmt then invert
        {4'd2,  4'd9,  1'b0, 1'b0, 12'h456, 12'h000, 12'h456}, // R2 unassigned code
        {4'd2,  4'd15, 1'b1, 1'b0, 12'h456, 12'h000, 12'h456}, // R2 fmt ignored
        {4'd10, 4'd4,  1'b0, 1'b0, 12'h000, 12'h000, 12'hAAA}, // R10 check restart
        {4'd10, 4'd8,  1'b0, 1'b0, 12'h000, 12'h000, 12'h3C5}, // R10 restart from second phase
        {4'd10, 4'd4,  1'b0, 1'b0, 12'h000, 12'h000, 12'hAAA}  // R10 back to check
    };

    task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %03h expected %03h", req, got, exp);
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [45:0] v;
        logic [W-1:0] prev_exp;
        string        prev_req;
        prev_exp = '0;
        prev_req = "";
        repeat (3) @(negedge clk);
        check("R1 reset", dout, 12'h000);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            if (i > 0) check(prev_req, dout, prev_exp);
            v    = VEC[i];
            mode = v[41:38];
            fmt  = v[37];
            inv  = v[36];
            din  = v[35:24];
            pn   = v[23:12];
            prev_exp = v[11:0];
            prev_req = $sformatf("R%0d vector %0d", v[45:42], i);
        end
        @(negedge clk);
        check(prev_req, dout, prev_exp);

        // R11: one clock of latency, output holds until the next edge
        mode = 4'd0; fmt = 1'b0; inv = 1'b0; din = 12'h111;
        @(negedge clk);
        check("R11 data after one clock", dout, 12'h111);
        din = 12'h222;
        #1;
        check("R11 held before edge", dout, 12'h111);
        @(negedge clk);
        check("R11 new data", dout, 12'h222);

        // R1 with R4: reset in the middle of the checkerboard
        mode = 4'd4;
        @(negedge clk);
        check("R4 first", dout, 12'hAAA);
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset mid pattern", dout, 12'h000);
        rst = 1'b0;
        @(negedge clk);
        check("R1 phase restarts", dout, 12'hAAA);
        @(negedge clk);
        check("R4 second after reset", dout, 12'h555);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule